// File: doc/BRIEF.md
# 72/64 Single-Error-Correct Double-Error-Detect Codec

This block protects 64-bit words with 8 check bits using a fixed odd-weight parity-check matrix. A combinational encoder turns a data word into its 8 check bits. A decoder takes a 72-bit codeword through a valid/ready handshake and computes the syndrome. It finds the flipped bit by matching the syndrome against the matrix columns, repairs a data bit when one is wrong, and reports the error position together with a correctable or an uncorrectable flag.

The codeword holds the data word in bits 63:0, with the upper 32-bit half in 63:32 and the lower half in 31:0. Check bit j sits at codeword index 64+j. Each decoded result is registered once and held until the consumer takes it.

Top module: `ecc_codec`

## Requirements
- R1: Each codeword index has an 8-bit column. Data bits 0..55 take the weight-3 values in lexicographic order of their set bit positions (a<b<c, with c varying fastest): 0x07, 0x0B, 0x13, ... 0xE0. Data bits 56..63 take 0x1F, 0x2F, 0x4F, 0x8F, 0x37, 0x57, 0x97, 0x67. Check bit j takes the one-hot value 1<<j. enc_check_o bit j is the XOR of all data bits whose column has bit j set.
- R2: A codeword whose check bits equal the encoding of its data yields out_data equal to the data, out_ce=0, out_ue=0 and out_err_pos=0.
- R3: A codeword with exactly one flipped data bit i (0..63) yields the original data, out_ce=1, out_ue=0 and out_err_pos=i.
- R4: A codeword with exactly one flipped check bit j yields unchanged data, out_ce=1, out_ue=0 and out_err_pos=64+j.
- R5: A codeword with two flipped bits yields out_ue=1, out_ce=0, out_err_pos=0, and out_data equal to the received data bits without any correction.
- R6: A word accepted when in_valid and in_ready are both high at a clock edge appears with out_valid=1 right after that edge, which is one cycle of latency.
- R7: While out_valid=1 and out_ready=0, in_ready is 0 and all result outputs hold their values.
- R8: During and right after reset, out_valid=0 and in_ready=1.
- R9: A nonzero syndrome that matches no column (for example 0x7F, from seven flipped check bits 0..6) sets out_ue=1 and out_ce=0, and leaves the data uncorrected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_data_i | input | 64 | Data word to encode |
| enc_check_o | output | 8 | Check bits for enc_data_i (combinational) |
| in_valid | input | 1 | Codeword presented to the decoder |
| in_ready | output | 1 | Decoder can take a codeword |
| in_codeword | input | 72 | Received codeword, data in 63:0, check in 71:64 |
| out_valid | output | 1 | Decoded result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Corrected data |
| out_err_pos | output | 7 | Codeword index of the corrected bit, 0 when there is none |
| out_ce | output | 1 | Single-bit error was located |
| out_ue | output | 1 | Error could not be corrected |

## Verification
The encoder output is combinational, so it is compared a moment after its input changes, within the same cycle. Decoder results are due one edge after the handshake. The bench drives each codeword at a falling edge and reads the outputs at the next falling edge, half a cycle after the capturing edge. The backpressure test holds out_ready low across two further edges and checks that the first result stays put and in_ready stays low. It then releases out_ready and expects the second word one edge later.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int CW_W   = DATA_W + CHK_W;
  localparam int POS_W  = $clog2(CW_W);

  // Matrix column of codeword index idx.
  function automatic logic [CHK_W-1:0] hcol(input int idx);
    logic [CHK_W-1:0] res;
    int n;
    res = '0;
    n = 0;
    if (idx >= DATA_W) begin
      res = CHK_W'(1) << (idx - DATA_W);
    end else if (idx >= 56) begin
      case (idx - 56)
        0: res = 8'h1F;
        1: res = 8'h2F;
        2: res = 8'h4F;
        3: res = 8'h8F;
        4: res = 8'h37;
        5: res = 8'h57;
        6: res = 8'h97;
        default: res = 8'h67;
      endcase
    end else begin
      for (int a = 0; a < 6; a++)
        for (int b = a + 1; b < 7; b++)
          for (int c = b + 1; c < 8; c++) begin
            if (n == idx) res = (8'h1 << a) | (8'h1 << b) | (8'h1 << c);
            n++;
          end
    end
    return res;
  endfunction

  // Data bits that feed check bit j.
  function automatic logic [DATA_W-1:0] chk_mask(input int j);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) begin
      logic [CHK_W-1:0] col;
      col = hcol(i);
      m[i] = col[j];
    end
    return m;
  endfunction
endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W
) (
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] check_o
);
  for (genvar j = 0; j < CW; j++) begin : g_chk
    localparam logic [DW-1:0] MASK = chk_mask(j);
    assign check_o[j] = ^(data_i & MASK);
  end
endmodule

// File: rtl/ecc_syndrome.sv
module ecc_syndrome
  import ecc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W
) (
  input  logic [DW+CW-1:0] codeword_i,
  output logic [CW-1:0]    syndrome_o
);
  logic [CW-1:0] recomputed;

  ecc_encoder #(.DW(DW), .CW(CW)) u_enc (
    .data_i  (codeword_i[DW-1:0]),
    .check_o (recomputed)
  );

  assign syndrome_o = recomputed ^ codeword_i[DW+CW-1:DW];
endmodule

// File: rtl/ecc_locator.sv
module ecc_locator
  import ecc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W,
  localparam int NW = DW + CW,
  localparam int PW = $clog2(NW)
) (
  input  logic [CW-1:0] syndrome_i,
  output logic [NW-1:0] hit_o,
  output logic [PW-1:0] pos_o,
  output logic          ce_o,
  output logic          ue_o
);
  for (genvar i = 0; i < NW; i++) begin : g_cmp
    localparam logic [CW-1:0] COL = hcol(i);
    assign hit_o[i] = (syndrome_i == COL);
  end

  always_comb begin
    pos_o = '0;
    for (int i = 0; i < NW; i++)
      if (hit_o[i]) pos_o = pos_o | PW'(i);
  end

  assign ce_o = |hit_o;
  assign ue_o = (|syndrome_i) && !ce_o;
endmodule

// File: rtl/ecc_codec.sv
module ecc_codec
  import ecc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W,
  localparam int NW = DW + CW,
  localparam int PW = $clog2(NW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] enc_data_i,
  output logic [CW-1:0] enc_check_o,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [NW-1:0] in_codeword,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [PW-1:0] out_err_pos,
  output logic          out_ce,
  output logic          out_ue
);
  logic [CW-1:0] syn;
  logic [NW-1:0] hit;
  logic [PW-1:0] pos_c;
  logic          ce_c, ue_c;
  logic          accept;
  logic          valid_d, valid_q;
  logic [DW-1:0] data_d, data_q;
  logic [PW-1:0] pos_q;
  logic          ce_q, ue_q;

  ecc_encoder #(.DW(DW), .CW(CW)) u_encoder (
    .data_i  (enc_data_i),
    .check_o (enc_check_o)
  );

  ecc_syndrome #(.DW(DW), .CW(CW)) u_syndrome (
    .codeword_i (in_codeword),
    .syndrome_o (syn)
  );

  ecc_locator #(.DW(DW), .CW(CW)) u_locator (
    .syndrome_i (syn),
    .hit_o      (hit),
    .pos_o      (pos_c),
    .ce_o       (ce_c),
    .ue_o       (ue_c)
  );

  assign in_ready = !valid_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    data_d  = in_codeword[DW-1:0] ^ hit[DW-1:0];
    valid_d = valid_q;
    if (accept)         valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      data_q <= data_d;
      pos_q  <= pos_c;
      ce_q   <= ce_c;
      ue_q   <= ue_c;
    end
  end

  assign out_valid   = valid_q;
  assign out_data    = data_q;
  assign out_err_pos = pos_q;
  assign out_ce      = ce_q;
  assign out_ue      = ue_q;
endmodule

// File: rtl/ecc_codec_chk.sv
module ecc_codec_chk #(
  parameter int DW = 64,
  parameter int PW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic [PW-1:0] out_err_pos,
  input logic          out_ce,
  input logic          out_ue
);
  always @(posedge clk)
    if (!rst_n) assert_reset_idle_R8: assert (!out_valid);

  assert_accept_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_err_pos)
                                   && $stable(out_ce) && $stable(out_ue)));

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_ce && out_ue));

  assert_pos_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ce) |-> (out_err_pos < PW'(72)));

  assert_pos_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ce) |-> (out_err_pos == '0));
endmodule

bind ecc_codec ecc_codec_chk #(.DW(DW), .PW(PW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_err_pos (out_err_pos),
  .out_ce      (out_ce),
  .out_ue      (out_ue)
);

// File: tb/ecc_codec_tb.sv
`timescale 1ns/1ps
module ecc_codec_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] enc_data_i;
  logic [7:0]  enc_check_o;
  logic        in_valid;
  logic        in_ready;
  logic [71:0] in_codeword;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] out_data;
  logic [6:0]  out_err_pos;
  logic        out_ce, out_ue;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #10 clk = ~clk;

  ecc_codec u_dut (
    .clk(clk), .rst_n(rst_n), .enc_data_i(enc_data_i), .enc_check_o(enc_check_o),
    .in_valid(in_valid), .in_ready(in_ready), .in_codeword(in_codeword),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_err_pos(out_err_pos), .out_ce(out_ce), .out_ue(out_ue)
  );

  localparam int NV = 8;
  localparam logic [63:0] VDATA [NV] = '{
    64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF, 64'hDEAD_BEEF_0000_0001,
    64'h8000_0000_0000_0000, 64'hA5A5_5A5A_F00F_0FF0, 64'h0000_0001_0000_0000, 64'h7777_2222_1111_8888};
  localparam logic [71:0] VERR [NV] = '{
    72'h0, 72'h0, 72'h1, 72'h80_0000_0000_0000_0000,
    72'h00_8000_0000_0000_0000, 72'h00_0000_0000_0000_0003, 72'h01_0000_0001_0000_0000, 72'h00_4000_0000_0000_0000};

  function automatic logic [7:0] ref_col(input int k);
    int n = 0;
    logic [7:0] r = 8'h0;
    logic [7:0] hi [8] = '{8'h1F, 8'h2F, 8'h4F, 8'h8F, 8'h37, 8'h57, 8'h97, 8'h67};
    if (k >= 64) return 8'h1 << (k - 64);
    if (k >= 56) return hi[k - 56];
    for (int a = 0; a < 8; a++)
      for (int b = a + 1; b < 8; b++)
        for (int c = b + 1; c < 8; c++) begin
          if (n == k) r = (8'h1 << a) | (8'h1 << b) | (8'h1 << c);
          n++;
        end
    return r;
  endfunction

  function automatic logic [7:0] ref_enc(input logic [63:0] d);
    logic [7:0] s = 8'h0;
    for (int i = 0; i < 64; i++) if (d[i]) s ^= ref_col(i);
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input string what);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  // Decode one codeword built from d with error mask err and compare.
  task automatic apply(input logic [63:0] d, input logic [71:0] err, input string req);
    logic [63:0] ed;
    logic [6:0]  ep;
    logic        ece, eue;
    int          nerr;
    nerr = $countones(err);
    ed = d; ep = '0; ece = 1'b0; eue = 1'b0;
    if (nerr == 1) begin
      ece = 1'b1;
      for (int i = 0; i < 72; i++) if (err[i]) ep = 7'(i);
    end else if (nerr > 1) begin
      eue = 1'b1;
      ed  = d ^ err[63:0];
    end
    @(negedge clk);
    enc_data_i  = d;
    in_codeword = {ref_enc(d), d} ^ err;
    in_valid    = 1'b1;
    out_ready   = 1'b1;
    #1;
    check(enc_check_o == ref_enc(d), "R1",
          $sformatf("check bits got %h exp %h", enc_check_o, ref_enc(d)));
    @(negedge clk);
    in_valid = 1'b0;
    check({out_valid, out_data, out_err_pos, out_ce, out_ue} == {1'b1, ed, ep, ece, eue}, req,
          $sformatf("got v=%b d=%h p=%0d ce=%b ue=%b exp v=1 d=%h p=%0d ce=%b ue=%b",
                    out_valid, out_data, out_err_pos, out_ce, out_ue, ed, ep, ece, eue));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_fail++;
        $display("FAIL watchdog: got %0d cycles exp under 100000", cycles);
        report();
      end
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_codeword = '0; enc_data_i = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R8",
          $sformatf("in reset got v=%b rdy=%b exp v=0 rdy=1", out_valid, in_ready));
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R8",
          $sformatf("after reset got v=%b rdy=%b exp v=0 rdy=1", out_valid, in_ready));

    // Vector table: error count selects the expected class.
    for (int v = 0; v < NV; v++)
      apply(VDATA[v], VERR[v], $countones(VERR[v]) == 0 ? "R2" :
            $countones(VERR[v]) == 2 ? "R5" : (VERR[v][71:64] != 0 ? "R4" : "R3"));

    // Every single-bit error on random words.
    for (int r = 0; r < 3; r++) begin
      logic [63:0] w;
      w = {$urandom, $urandom};
      apply(w, 72'h0, "R2");
      for (int k = 0; k < 72; k++)
        apply(w, 72'h1 << k, k < 64 ? "R3" : "R4");
    end

    // Sampled double-bit errors.
    for (int r = 0; r < 150; r++) begin
      int a, b;
      a = $urandom_range(71, 0);
      b = $urandom_range(71, 0);
      if (b == a) b = (a + 1) % 72;
      apply({$urandom, $urandom}, (72'h1 << a) | (72'h1 << b), "R5");
    end

    // Syndrome 0x7F matches no column.
    apply(64'h0F0F_1234_5678_9ABC, 72'h7F << 64, "R9");

    // Latency: idle before accept, valid one edge after.
    @(negedge clk);
    check(out_valid == 1'b0, "R6", $sformatf("idle got v=%b exp 0", out_valid));
    in_codeword = {ref_enc(64'h55), 64'h55};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1 && out_data == 64'h55, "R6",
          $sformatf("got v=%b d=%h exp v=1 d=55", out_valid, out_data));

    // Backpressure.
    @(negedge clk);
    out_ready = 1'b0;
    in_codeword = {ref_enc(64'hAAAA), 64'hAAAA} ^ 72'h4;
    in_valid = 1'b1;
    @(negedge clk);
    in_codeword = {ref_enc(64'hBBBB), 64'hBBBB};
    #1;
    check(in_ready == 1'b0, "R7", $sformatf("stalled got rdy=%b exp 0", in_ready));
    repeat (2) @(negedge clk);
    check(out_valid && out_data == 64'hAAAA && out_ce && out_err_pos == 7'd2 && !in_ready, "R7",
          $sformatf("hold got v=%b d=%h p=%0d rdy=%b exp v=1 d=aaaa p=2 rdy=0",
                    out_valid, out_data, out_err_pos, in_ready));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_data == 64'hBBBB && !out_ce && !out_ue, "R7",
          $sformatf("release got v=%b d=%h exp v=1 d=bbbb", out_valid, out_data));

    // Reset clears a pending result.
    rst_n = 1'b0;
    #1;
    check(out_valid == 1'b0, "R8", $sformatf("async reset got v=%b exp 0", out_valid));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    report();
  end
endmodule